// File: doc/BRIEF.md
# 32-bit Eight-Operation ALU with Zero Flag

This block is the arithmetic logic unit of a simple register-to-register datapath. Two 32-bit operands arrive from the two read ports of a register file. A 3-bit select picks one of eight operations: two arithmetic, four bitwise and two shifts. The block returns a 32-bit result and a flag that is high when that result is all zeros. Branch logic can use the flag directly, for example to test two registers for equality with a subtract.

The unit is purely combinational and holds no state. Inside it, an adder/subtractor, a bitwise unit and a barrel shifter work side by side, and one multiplexer picks the result that the select code names. A separate detector derives the zero flag from the chosen result. The data pins are plain, with no handshake. A register stage placed before or after the block decides when its values are captured.

Top module: `alu32_core`

## Requirements
- R1: Select code 000 gives the sum of the two operands modulo 2^32, with no overflow indication.
- R2: Select code 001 gives the first operand minus the second, modulo 2^32, with no overflow indication.
- R3: Select code 010 gives the bitwise AND of the operands.
- R4: Select code 011 gives the bitwise OR of the operands.
- R5: Select code 100 gives the bitwise NOR (inverted OR) of the operands.
- R6: Select code 101 gives the bitwise XOR of the operands.
- R7: Select code 110 shifts the first operand left by the amount in bits [4:0] of the second operand, filling with zeros. Bits [31:5] of the second operand have no effect, so an amount field of 0 returns the first operand unchanged.
- R8: Select code 111 shifts the first operand right logically by the amount in bits [4:0] of the second operand, filling with zeros at the top. Bits [31:5] of the second operand have no effect.
- R9: The zero output is 1 exactly when all 32 result bits are 0, for every select code. With code 001 this means it is 1 exactly when the two operands are equal.
- R10: The result and zero outputs follow the inputs within the same clock cycle, through no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand; the value that is shifted |
| b_i | input | 32 | Second operand; bits [4:0] give the shift amount |
| op_i | input | 3 | Operation select code |
| result_o | output | 32 | Result of the selected operation |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The bench builds the block with the default data width of 32, so the derived shift-amount field is 5 bits wide. That brings within reach the case where the amount field wraps: a second operand of 32 or 0xFFFFFFE0 gives an amount of 0. The bench also covers the full-width edge shifts of 31 and the carry out of bit 31 on add and subtract. Directed vectors cover these edges, the all-ones and all-zeros operands, and equal operands on subtract. A few hundred seeded vectors then sweep every select code. Each vector is compared in the same cycle against a behavioural model written with wide integer arithmetic.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_NOR = 3'b100,
    OP_XOR = 3'b101,
    OP_SLL = 3'b110,
    OP_SRL = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu32_arith.sv
module alu32_arith #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = b_i ^ {W{sub_i}};
    sum_o = a_i + b_eff + W'(sub_i);
  end

  // R1 / R2: the output undone by the inverse operation gives back a_i
  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i})) begin
      if (!sub_i) begin
        a_r1_add_inverse: assert (W'(sum_o - b_i) == a_i)
          else $error("add result does not invert");
      end else begin
        a_r2_sub_inverse: assert (W'(sum_o + b_i) == a_i)
          else $error("sub result does not invert");
      end
    end
  end
endmodule

// File: rtl/alu32_logic.sv
module alu32_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]       a_i,
  input  logic [W-1:0]       b_i,
  input  alu32_pkg::alu_op_e op_i,
  output logic [W-1:0]       res_o
);
  import alu32_pkg::*;

  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_NOR:  res_o = ~(a_i | b_i);
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      if (op_i == OP_AND) begin
        a_r3_and_subset: assert (((res_o & ~a_i) == '0) && ((res_o & ~b_i) == '0))
          else $error("and result has bits outside an operand");
      end
      if (op_i == OP_OR) begin
        a_r4_or_cover: assert (((a_i & ~res_o) == '0) && ((b_i & ~res_o) == '0))
          else $error("or result drops operand bits");
      end
      if (op_i == OP_NOR) begin
        a_r5_nor_disjoint: assert (((res_o & a_i) == '0) && ((res_o & b_i) == '0))
          else $error("nor result overlaps an operand");
      end
      if (op_i == OP_XOR) begin
        a_r6_xor_undo: assert ((res_o ^ a_i) == b_i)
          else $error("xor result does not undo");
      end
    end
  end
endmodule

// File: rtl/alu32_shift.sv
module alu32_shift #(
  parameter int unsigned W    = 32,
  parameter int unsigned SH_W = $clog2(W)
) (
  input  logic [W-1:0]    a_i,
  input  logic [SH_W-1:0] amt_i,
  input  logic            left_i,
  output logic [W-1:0]    res_o
);
  logic [W-1:0] a_rev;
  logic [W-1:0] out_rev;
  logic [W-1:0] stage_in;
  logic [W-1:0] stg [SH_W+1];

  // Bit reversal lets a single right-shifting barrel serve both directions
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign a_rev[i]   = a_i[W-1-i];
    assign out_rev[i] = stg[SH_W][W-1-i];
  end

  assign stage_in = left_i ? a_rev : a_i;
  assign stg[0]   = stage_in;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned DIST = 1 << k;
    assign stg[k+1] = amt_i[k] ? (stg[k] >> DIST) : stg[k];
  end

  assign res_o = left_i ? out_rev : stg[SH_W];

  always_comb begin
    if (!$isunknown({a_i, amt_i, left_i})) begin
      if (amt_i == '0) begin
        a_r7_zero_amount_identity: assert (res_o == a_i)
          else $error("shift by zero altered operand");
      end else if (left_i) begin
        a_r7_left_zero_fill: assert (res_o[0] == 1'b0)
          else $error("left shift did not fill with zero");
      end else begin
        a_r8_right_zero_fill: assert (res_o[W-1] == 1'b0)
          else $error("right shift did not fill with zero");
      end
    end
  end
endmodule

// File: rtl/alu32_zero_detect.sv
module alu32_zero_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  assign zero_o = ~|val_i;
endmodule

// File: rtl/alu32_core.sv
module alu32_core #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);
  import alu32_pkg::*;

  localparam int unsigned SH_W = $clog2(DATA_W);

  alu_op_e           op;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] shift_res;

  assign op = alu_op_e'(op_i);

  alu32_arith #(.W(DATA_W)) arith_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op == OP_SUB),
    .sum_o (arith_res)
  );

  alu32_logic #(.W(DATA_W)) logic_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op),
    .res_o (logic_res)
  );

  alu32_shift #(.W(DATA_W), .SH_W(SH_W)) shift_i (
    .a_i    (a_i),
    .amt_i  (b_i[SH_W-1:0]),
    .left_i (op == OP_SLL),
    .res_o  (shift_res)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:                 result_o = arith_res;
      OP_AND, OP_OR, OP_NOR, OP_XOR: result_o = logic_res;
      OP_SLL, OP_SRL:                 result_o = shift_res;
      default:                        result_o = '0;
    endcase
  end

  alu32_zero_detect #(.W(DATA_W)) zero_i (
    .val_i  (result_o),
    .zero_o (zero_o)
  );

  // R9: on subtract the flag is an equality compare of the two ports
  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      if (op == OP_SUB) begin
        a_r9_sub_equality: assert (zero_o == (a_i == b_i))
          else $error("zero flag disagrees with operand equality");
      end
      if (zero_o) begin
        a_r9_flag_implies_clear: assert (result_o == '0)
          else $error("zero flag high on nonzero result");
      end
    end
  end
endmodule

// File: tb/alu32_core_tb_top.sv
module alu32_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [2:0]  op;
  logic [31:0] result;
  logic        zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu32_core dut_i (
    .a_i      (a),
    .b_i      (b),
    .op_i     (op),
    .result_o (result),
    .zero_o   (zero)
  );

  typedef struct {
    logic [31:0] va;
    logic [31:0] vb;
    logic [2:0]  vop;
  } vec_t;

  vec_t vq[$];

  function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic [2:0] o);
    longint unsigned wx = longint'(x);
    longint unsigned wy = longint'(y);
    int sh = int'(y % 32);
    longint unsigned mod = 64'h1_0000_0000;
    case (o)
      3'd0: return 32'((wx + wy) % mod);
      3'd1: return 32'((wx + mod - wy) % mod);
      3'd2: return x & y;
      3'd3: return x | y;
      3'd4: return ~(x | y);
      3'd5: return x ^ y;
      3'd6: return 32'((wx * (64'd1 << sh)) % mod);
      default: return 32'(wx / (64'd1 << sh));
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Drive at the rising edge; compare at the falling edge of the same cycle (R10)
  task automatic apply(input vec_t v);
    logic [31:0] exp_r;
    logic        exp_z;
    @(posedge clk);
    a  = v.va;
    b  = v.vb;
    op = v.vop;
    exp_r = model(v.va, v.vb, v.vop);
    exp_z = (exp_r == 32'd0);
    @(negedge clk);
    n_checks++;
    if (result !== exp_r) begin
      n_fail++;
      $display("FAIL %s/R10 op=%0d a=%h b=%h result actual=%h expected=%h",
               tag_of(v.vop), v.vop, v.va, v.vb, result, exp_r);
    end
    n_checks++;
    if (zero !== exp_z) begin
      n_fail++;
      $display("FAIL R9 op=%0d a=%h b=%h zero actual=%b expected=%b",
               v.vop, v.va, v.vb, zero, exp_z);
    end
  endtask

  task automatic push(input logic [31:0] x, input logic [31:0] y, input logic [2:0] o);
    vec_t v;
    v.va = x; v.vb = y; v.vop = o;
    vq.push_back(v);
  endtask

  initial begin
    a = '0; b = '0; op = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: all-zero inputs give a zero sum and a raised flag (R1, R9)
    @(negedge clk);
    n_checks++;
    if (result !== 32'd0 || zero !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 idle actual=%h/%b expected=00000000/1", result, zero);
    end
    // R1: wrap to zero
    push(32'hFFFF_FFFF, 32'h0000_0001, 3'd0);
    push(32'h1234_5678, 32'h8765_4321, 3'd0);
    // R2: borrow wrap, equal operands
    push(32'h0000_0005, 32'h0000_0007, 3'd1);
    push(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'd1);
    push(32'h0000_0000, 32'h8000_0000, 3'd1);
    // R3..R6
    push(32'hF0F0_F0F0, 32'hFF00_FF00, 3'd2);
    push(32'h0F0F_0000, 32'hF0F0_0000, 3'd2);
    push(32'hF0F0_F0F0, 32'h0F0F_0000, 3'd3);
    push(32'hFFFF_FFFF, 32'h0000_0000, 3'd4);
    push(32'h0000_0000, 32'h0000_0000, 3'd4);
    push(32'hA5A5_A5A5, 32'hA5A5_A5A5, 3'd5);
    push(32'hA5A5_A5A5, 32'h5A5A_5A5A, 3'd5);
    // R7: amounts 0, 1, 31, upper bits ignored
    push(32'h8000_0001, 32'h0000_0000, 3'd6);
    push(32'h8000_0001, 32'h0000_0001, 3'd6);
    push(32'h0000_0003, 32'h0000_001F, 3'd6);
    push(32'h1234_5678, 32'h0000_0020, 3'd6);
    push(32'h1234_5678, 32'hFFFF_FFE4, 3'd6);
    push(32'h8000_0000, 32'h0000_0001, 3'd6);
    // R8: logical, no sign fill
    push(32'h8000_0000, 32'h0000_001F, 3'd7);
    push(32'hFFFF_FFFF, 32'h0000_0004, 3'd7);
    push(32'h8765_4321, 32'hFFFF_FFE0, 3'd7);
    push(32'h0000_0001, 32'h0000_0001, 3'd7);
    void'($urandom(32'h5EED));
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [31:0] rb = $urandom();
      if (i % 5 == 0) rb = rb & 32'h0000_003F;
      push($urandom(), rb, 3'(i % 8));
    end
    while (vq.size() > 0) apply(vq.pop_front());
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule